// File: doc/BRIEF.md
# Partial-Width Register File with Merge-on-Write

This block holds a small bank of 64-bit general-purpose registers that can be written and read through narrower views of each register: the whole word, the low half, the low 16 bits, the low byte, and the byte just above it (bits 15:8). A write names a register, a view and a data word. The block merges the data into the stored value under rules that differ by view. A half-width write clears the upper half of the register. A 16-bit or byte write leaves every bit outside its own field as it was.

Two combinational read ports each select a register and a view. They return that view zero-extended to the full word. When a port reads the register being written in the same cycle, it sees the value after the merge. A register value therefore becomes visible in the cycle it is written, and from then on stays in storage.

Top module: `subreg_file`

## Requirements
- R1: A synchronous reset clears every register to zero; after reset every read of any register in the full view returns zero.
- R2: A write with view code 3'b000 replaces all 64 bits of the register with wr_data.
- R3: A write with view code 3'b001 loads bits 31:0 from wr_data[31:0] and forces bits 63:32 to zero, also when the written value equals the stored one.
- R4: A write with view code 3'b010 loads bits 15:0 from wr_data[15:0] and keeps bits 63:16.
- R5: A write with view code 3'b011 loads bits 7:0 from wr_data[7:0] and keeps bits 63:8, including bits 15:8.
- R6: A write with view code 3'b100 loads bits 15:8 from wr_data[7:0] and keeps bits 63:16 and 7:0.
- R7: A write with view codes 3'b101, 3'b110 or 3'b111, or with wr_en low, changes no register.
- R8: A read uses the same view codes and returns its field in the low bits with zeros above: code 000 gives bits 63:0, 001 gives 31:0, 010 gives 15:0, 011 gives 7:0, 100 gives bits 15:8 in result bits 7:0. Codes 101 to 111 read as zero.
- R9: Each read port that selects the register written in the same cycle by a valid write returns the merged value, and the two ports work independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_view | input | 3 | View of the write (codes in R2 to R7) |
| wr_data | input | 64 | Write data, field taken from its low bits |
| rd_a_idx | input | 4 | Register read on port A |
| rd_a_view | input | 3 | View read on port A |
| rd_a_data | output | 64 | Port A result, zero-extended |
| rd_b_idx | input | 4 | Register read on port B |
| rd_b_view | input | 3 | View read on port B |
| rd_b_data | output | 64 | Port B result, zero-extended |

## Verification
Read data is combinational. A read that hits the register under write therefore shows the merged value in the same cycle the write is presented, and any later read shows the stored result from the cycle after the clock edge on. The driver applies each operation just after a falling edge and queues the two port values it expects, with the bypass already folded in. The monitor compares them a few nanoseconds later, still before the rising edge that commits the write, so every result is checked in the cycle it is due. Reset is applied with no operations queued, and reads that follow it expect zero.

// File: rtl/subreg_pkg.sv
package subreg_pkg;

   // View selector shared by the write port and both read ports
   typedef enum logic [2:0] {
      VW_FULL = 3'b000,
      VW_HALF = 3'b001,
      VW_WORD = 3'b010,
      VW_BLO  = 3'b011,
      VW_BHI  = 3'b100
   } view_e;

   function automatic logic view_is_valid(input logic [2:0] v);
      return (v <= 3'b100);
   endfunction

endpackage

// File: rtl/subreg_merge.sv
module subreg_merge
   import subreg_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] old_word,
   input  logic [2:0]      view,
   input  logic [XLEN-1:0] data,
   output logic [XLEN-1:0] new_word,
   output logic            legal
);
   localparam int HALF = XLEN / 2;

   always_comb begin
      legal    = 1'b1;
      new_word = old_word;
      case (view)
         VW_FULL: new_word = data;
         VW_HALF: new_word = {{(XLEN-HALF){1'b0}}, data[HALF-1:0]};
         VW_WORD: new_word = {old_word[XLEN-1:16], data[15:0]};
         VW_BLO:  new_word = {old_word[XLEN-1:8], data[7:0]};
         VW_BHI:  new_word = {old_word[XLEN-1:16], data[7:0], old_word[7:0]};
         default: legal    = 1'b0;
      endcase
   end
endmodule

// File: rtl/subreg_extract.sv
module subreg_extract
   import subreg_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] word,
   input  logic [2:0]      view,
   output logic [XLEN-1:0] field
);
   localparam int HALF = XLEN / 2;

   always_comb begin
      field = '0;
      case (view)
         VW_FULL: field = word;
         VW_HALF: field[HALF-1:0] = word[HALF-1:0];
         VW_WORD: field[15:0] = word[15:0];
         VW_BLO:  field[7:0] = word[7:0];
         VW_BHI:  field[7:0] = word[15:8];
         default: field = '0;
      endcase
   end
endmodule

// File: rtl/subreg_store.sv
module subreg_store #(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           we,
   input  logic [IDX_W-1:0]               idx,
   input  logic [XLEN-1:0]                wdata,
   output logic [NUM_REGS-1:0][XLEN-1:0]  words
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            words[g] <= '0;
         else if (we && (idx == IDX_W'(g)))
            words[g] <= wdata;
      end
   end
endmodule

// File: rtl/subreg_file.sv
module subreg_file
   import subreg_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [2:0]       wr_view,
   input  logic [XLEN-1:0]  wr_data,
   input  logic [IDX_W-1:0] rd_a_idx,
   input  logic [2:0]       rd_a_view,
   output logic [XLEN-1:0]  rd_a_data,
   input  logic [IDX_W-1:0] rd_b_idx,
   input  logic [2:0]       rd_b_view,
   output logic [XLEN-1:0]  rd_b_data
);
   localparam int NUM_RD = 2;

   if (XLEN < 32 || (XLEN % 16) != 0) begin : g_bad_xlen
      $error("subreg_file: XLEN must be a multiple of 16 and at least 32");
   end
   if ((1 << IDX_W) != NUM_REGS || NUM_REGS < 2) begin : g_bad_regs
      $error("subreg_file: NUM_REGS must be a power of two of at least 2");
   end

   logic [NUM_REGS-1:0][XLEN-1:0] words;
   logic [XLEN-1:0]               old_word;
   logic [XLEN-1:0]               merged;
   logic                          legal;
   logic                          commit;

   assign old_word = words[wr_idx];

   subreg_merge #(.XLEN(XLEN)) u_merge (
      .old_word (old_word),
      .view     (wr_view),
      .data     (wr_data),
      .new_word (merged),
      .legal    (legal)
   );

   assign commit = wr_en && legal;

   subreg_store #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (commit),
      .idx   (wr_idx),
      .wdata (merged),
      .words (words)
   );

   logic [NUM_RD-1:0][IDX_W-1:0] rd_idx;
   logic [NUM_RD-1:0][2:0]       rd_view;
   logic [NUM_RD-1:0][XLEN-1:0]  rd_field;

   assign rd_idx  = {rd_b_idx, rd_a_idx};
   assign rd_view = {rd_b_view, rd_a_view};

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [XLEN-1:0] src;
      assign src = (commit && rd_idx[p] == wr_idx) ? merged : words[rd_idx[p]];
      subreg_extract #(.XLEN(XLEN)) u_ext (
         .word  (src),
         .view  (rd_view[p]),
         .field (rd_field[p])
      );
   end

   assign rd_a_data = rd_field[0];
   assign rd_b_data = rd_field[1];

endmodule

// File: rtl/subreg_file_chk.sv
module subreg_file_chk
   import subreg_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [2:0]       wr_view,
   input logic [XLEN-1:0]  wr_data,
   input logic [IDX_W-1:0] rd_a_idx,
   input logic [2:0]       rd_a_view,
   input logic [XLEN-1:0]  rd_a_data,
   input logic [IDX_W-1:0] rd_b_idx,
   input logic [2:0]       rd_b_view,
   input logic [XLEN-1:0]  rd_b_data,
   input logic [XLEN-1:0]  old_word
);
   logic a_full_hit;
   assign a_full_hit = wr_en && rd_a_idx == wr_idx && rd_a_view == VW_FULL;

   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) && !wr_en |-> rd_a_data == '0 && rd_b_data == '0);

   // R2
   full_write_chk: assert property (@(posedge clk) disable iff (rst)
      a_full_hit && wr_view == VW_FULL |-> rd_a_data == wr_data);

   // R3
   half_clear_chk: assert property (@(posedge clk) disable iff (rst)
      a_full_hit && wr_view == VW_HALF |->
         rd_a_data[XLEN-1:XLEN/2] == '0 && rd_a_data[XLEN/2-1:0] == wr_data[XLEN/2-1:0]);

   // R4
   word_keep_chk: assert property (@(posedge clk) disable iff (rst)
      a_full_hit && wr_view == VW_WORD |->
         rd_a_data[XLEN-1:16] == old_word[XLEN-1:16] && rd_a_data[15:0] == wr_data[15:0]);

   // R5
   blo_keep_chk: assert property (@(posedge clk) disable iff (rst)
      a_full_hit && wr_view == VW_BLO |->
         rd_a_data[XLEN-1:8] == old_word[XLEN-1:8] && rd_a_data[7:0] == wr_data[7:0]);

   // R6
   bhi_keep_chk: assert property (@(posedge clk) disable iff (rst)
      a_full_hit && wr_view == VW_BHI |->
         rd_a_data[XLEN-1:16] == old_word[XLEN-1:16] && rd_a_data[15:8] == wr_data[7:0]
         && rd_a_data[7:0] == old_word[7:0]);

   // R7
   bad_view_chk: assert property (@(posedge clk) disable iff (rst)
      a_full_hit && wr_view > 3'b100 |-> rd_a_data == old_word);

   // R8
   narrow_zext_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_b_view == VW_BLO || rd_b_view == VW_BHI) |-> rd_b_data[XLEN-1:8] == '0);

   // R8
   bad_read_chk: assert property (@(posedge clk) disable iff (rst)
      rd_a_view > 3'b100 |-> rd_a_data == '0);

   // R9
   bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && view_is_valid(wr_view) && rd_b_idx == wr_idx && rd_b_view == VW_FULL |=>
         (!(rd_b_idx == $past(rd_b_idx) && rd_b_view == VW_FULL && !wr_en)
          || rd_b_data == $past(rd_b_data)));

endmodule

bind subreg_file subreg_file_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_view   (wr_view),
   .wr_data   (wr_data),
   .rd_a_idx  (rd_a_idx),
   .rd_a_view (rd_a_view),
   .rd_a_data (rd_a_data),
   .rd_b_idx  (rd_b_idx),
   .rd_b_view (rd_b_view),
   .rd_b_data (rd_b_data),
   .old_word  (old_word)
);

// File: tb/subreg_file_test.sv
module subreg_file_test;
   localparam int NREG = 16;
   localparam logic [2:0] V64 = 3'b000, V32 = 3'b001, V16 = 3'b010,
                          VLO = 3'b011, VHI = 3'b100;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [3:0]  wr_idx, rd_a_idx, rd_b_idx;
   logic [2:0]  wr_view, rd_a_view, rd_b_view;
   logic [63:0] wr_data, rd_a_data, rd_b_data;

   always #5 clk = ~clk;

   subreg_file uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
      .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_view(rd_a_view),
      .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_view(rd_b_view),
      .rd_b_data(rd_b_data)
   );

   typedef struct {
      logic [63:0] ea;
      logic [63:0] eb;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [63:0] model [NREG];
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done  = 0;

   function automatic logic [63:0] ref_merge(input logic [63:0] o, input logic [2:0] v,
                                             input logic [63:0] d);
      case (v)
         V64: return d;
         V32: return {32'h0, d[31:0]};
         V16: return {o[63:16], d[15:0]};
         VLO: return {o[63:8], d[7:0]};
         VHI: return {o[63:16], d[7:0], o[7:0]};
         default: return o;
      endcase
   endfunction

   function automatic logic [63:0] ref_view(input logic [63:0] w, input logic [2:0] v);
      case (v)
         V64: return w;
         V32: return {32'h0, w[31:0]};
         V16: return {48'h0, w[15:0]};
         VLO: return {56'h0, w[7:0]};
         VHI: return {56'h0, w[15:8]};
         default: return 64'h0;
      endcase
   endfunction

   // Driver: apply one operation and queue what both ports must show
   task automatic op(input bit we, input logic [3:0] wi, input logic [2:0] wv,
                     input logic [63:0] wd, input logic [3:0] ai, input logic [2:0] av,
                     input logic [3:0] bi, input logic [2:0] bv, input string tag);
      exp_t        e;
      logic [63:0] nv;
      bit          hit;
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
      rd_a_idx = ai; rd_a_view = av; rd_b_idx = bi; rd_b_view = bv;
      hit = we && (wv <= 3'b100);
      nv  = ref_merge(model[wi], wv, wd);
      e.ea  = ref_view((hit && ai == wi) ? nv : model[ai], av);
      e.eb  = ref_view((hit && bi == wi) ? nv : model[bi], bv);
      e.tag = tag;
      sb.push_back(e);
      if (hit) model[wi] = nv;
   endtask

   task automatic do_reset(input int cycles);
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0;
      repeat (cycles) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NREG; i++) model[i] = 64'h0;
   endtask

   // Monitor: compare before the rising edge of the cycle an operation is applied
   always @(negedge clk) begin
      exp_t e;
      #3;
      if (sb.size() > 0) begin
         e = sb.pop_front();
         n_cmp++;
         if (rd_a_data !== e.ea) begin
            n_bad++;
            $display("FAIL %s port A: actual %h expected %h", e.tag, rd_a_data, e.ea);
         end
         n_cmp++;
         if (rd_b_data !== e.eb) begin
            n_bad++;
            $display("FAIL %s port B: actual %h expected %h", e.tag, rd_b_data, e.eb);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
      rd_a_idx = '0; rd_a_view = '0; rd_b_idx = '0; rd_b_view = '0;
      for (int i = 0; i < NREG; i++) model[i] = 64'h0;
      do_reset(3);

      // R1: every register reads zero after reset
      for (int i = 0; i < NREG; i += 2)
         op(0, 0, V64, 0, 4'(i), V64, 4'(i + 1), V64, "R1 reset");

      // R2: full write, bypassed and stored
      op(1, 3, V64, 64'hDEADBEEF_CAFEF00D, 3, V64, 5, V64, "R2 full write");
      op(0, 0, V64, 0, 3, V64, 3, V32, "R2 read back");

      // R3: half write clears the upper half, also with the same value
      op(1, 3, V32, 64'hFFFFFFFF_12345678, 3, V64, 3, V32, "R3 half write");
      op(1, 7, V64, 64'hFFFFFFFF_FFFFFFFF, 7, V64, 0, V64, "R3 setup");
      op(1, 7, V32, 64'hFFFFFFFF_FFFFFFFF, 7, V64, 7, V16, "R3 same value");
      op(0, 0, V64, 0, 7, V64, 3, V64, "R3 stored");

      // R4: 16-bit write keeps bits 63:16
      op(1, 8, V64, 64'h01234567_89ABCDEF, 8, V64, 8, V64, "R4 setup");
      op(1, 8, V16, 64'hFFFFFFFF_FFFF5AA5, 8, V64, 8, V16, "R4 word write");

      // R5: low byte write keeps the high byte
      op(1, 8, VLO, 64'hAAAAAAAA_AAAAAA77, 8, V64, 8, VHI, "R5 low byte");
      op(0, 0, V64, 0, 8, V16, 8, VLO, "R5 stored");

      // R6: high byte write takes wr_data[7:0]
      op(1, 8, VHI, 64'h55555555_555555C3, 8, V64, 8, VHI, "R6 high byte");
      op(0, 0, V64, 0, 8, V64, 8, VLO, "R6 stored");

      // R7: invalid views and wr_en low leave the register alone
      op(1, 8, 3'b101, 64'h1111111111111111, 8, V64, 8, V64, "R7 code 5");
      op(1, 8, 3'b110, 64'h2222222222222222, 8, V64, 8, V64, "R7 code 6");
      op(1, 8, 3'b111, 64'h3333333333333333, 8, V64, 8, V64, "R7 code 7");
      op(0, 8, V64, 64'h4444444444444444, 8, V64, 8, V64, "R7 wr_en low");
      op(0, 0, V64, 0, 8, V64, 8, V64, "R7 after");

      // R8: every read view of one register
      op(0, 0, V64, 0, 8, V64, 8, V32, "R8 views a");
      op(0, 0, V64, 0, 8, V16, 8, VLO, "R8 views b");
      op(0, 0, V64, 0, 8, VHI, 8, 3'b101, "R8 views c");
      op(0, 0, V64, 0, 8, 3'b110, 8, 3'b111, "R8 views d");

      // R9: ports independent, one hitting the written register
      op(1, 9, V64, 64'h0F0E0D0C_0B0A0908, 9, VHI, 8, V64, "R9 split ports");
      op(1, 9, VLO, 64'h00000000_000000EE, 8, V16, 9, V64, "R9 port B hit");
      op(1, 9, V16, 64'h00000000_0000BEEF, 9, V32, 9, VLO, "R9 both hit");

      // Mixed random traffic
      for (int k = 0; k < 600; k++)
         op(bit'($urandom_range(0, 1)), 4'($urandom), 3'($urandom),
            {$urandom, $urandom}, 4'($urandom), 3'($urandom),
            4'($urandom), 3'($urandom), "mixed random traffic");

      // R1: reset in mid-run clears everything again
      do_reset(2);
      for (int i = 0; i < NREG; i += 2)
         op(0, 0, V64, 0, 4'(i), V64, 4'(i + 1), V64, "R1 reset again");

      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule